// File: doc/BRIEF.md
# Oversampled Manchester Frame Receiver

This block turns a framed Manchester stream on a single input line into bytes. An internal prescaler produces an oversampling tick at eight times the selected bit rate. On each tick the synchronised line level is examined by a decoder state machine. The machine first waits for a quiet low level. It then hunts for a two-cell sync pattern, recovers eight data bits least significant bit first, and checks the closing pattern. Each mid-cell transition resynchronises the cell timing, and the spacing between consecutive mid-cell transitions is measured against a tolerance window.

A byte that passes every check lands in a one-entry receive register and raises the full flag. If the register is still full, the byte is dropped and an overrun flag is raised instead. A cell pattern fault, a timing fault, a framing fault or the removal of enable throws away the partial byte and returns the decoder to its start state. A host clears the flags with read strobes. A single interrupt request reflects the two flags.

Frame on the line: at least one cell low, two sync cells held high, eight data cells, one trailing cell held high, two pause cells held low. A data 0 is high in the first half of its cell and low in the second. A data 1 is low first and then high.

Top module: `mcd_rx`

## Requirements
- R1: After reset, rx_full, rx_overrun and irq are 0. While enable is 0, no frame is accepted and rx_full stays 0.
- R2: A valid frame delivers its byte (first data cell = bit 0) to rx_data and sets rx_full. Data 0 is high-then-low and data 1 is low-then-high.
- R3: One bit cell lasts 8 * BASE_DIV * 2^rate_sel clock cycles (rate_sel 0..3). Frames sent at the selected rate decode at every setting.
- R4: Consecutive mid-cell transitions must lie 7 to 9 oversample ticks apart. The first data cell's mid transition must lie 19 to 21 ticks after the sync rising edge. Cells about 3% off nominal are accepted. Cells 25% fast or slow are rejected.
- R5: A data cell whose two halves vote to the same level (no mid-cell transition) is a format error, and the byte is discarded.
- R6: A trailing cell that is not high, or any transition within the two pause cells, discards the byte.
- R7: A valid byte that arrives while rx_full is 1 sets rx_overrun and leaves rx_data unchanged.
- R8: A rd_data strobe clears rx_full. rx_overrun clears only on a rd_data strobe that follows a rd_status strobe seen while rx_overrun was 1. A rd_data strobe alone leaves rx_overrun set.
- R9: Dropping enable in the middle of a frame discards the partial byte. After enable returns, the next full frame decodes.
- R10: After any rejected frame the decoder restarts its hunt, and the following valid frame decodes.
- R11: irq is 1 exactly when rx_full or rx_overrun is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Decoder enable; low forces the start state |
| rate_sel | input | 2 | Bit rate select, cell = 8*BASE_DIV*2^rate_sel clocks |
| line_in | input | 1 | Asynchronous Manchester line input |
| rd_status | input | 1 | Status read strobe (arms overrun clearing) |
| rd_data | input | 1 | Receive register read strobe |
| rx_data | output | 8 | Receive register |
| rx_full | output | 1 | Receive register holds an unread byte |
| rx_overrun | output | 1 | A byte was lost because the register was full |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check how the receive register and flags react when the decoder hands over a byte. They cover the load when the register is empty, the overrun when it is full, the clearing by a read, the stickiness of the overrun flag and the silence of the decoder while disabled. Only the bench scenarios can show whether a line waveform is accepted or rejected. Those scenarios cover tolerance at each rate, cells without a mid transition, broken end patterns, enable removed mid-frame, and recovery after each fault, all compared with a bench model of the flags.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

  typedef enum logic [2:0] {
    ST_START,
    ST_HUNT,
    ST_SYNC,
    ST_DATA,
    ST_TRAIL,
    ST_PAUSE
  } dec_state_t;

  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction

endpackage

// File: rtl/mcd_sync.sv
module mcd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q
);
  logic [STAGES-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[STAGES-2:0], d_async};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mcd_prescale.sv
module mcd_prescale #(
  parameter int BASE_DIV = 4,
  parameter int RATE_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate_sel,
  output logic              tick
);
  localparam int MAX_DIV = BASE_DIV << ((1 << RATE_W) - 1);
  localparam int CW      = $clog2(MAX_DIV) + 1;

  logic [CW-1:0] cnt, cnt_n, lim;
  logic          tick_n;

  always_comb begin
    lim    = CW'((BASE_DIV << rate_sel) - 1);
    cnt_n  = cnt;
    tick_n = 1'b0;
    if (!run) begin
      cnt_n = '0;
    end else if (cnt >= lim) begin
      cnt_n  = '0;
      tick_n = 1'b1;
    end else begin
      cnt_n = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      cnt  <= cnt_n;
      tick <= tick_n;
    end
  end
endmodule

// File: rtl/mcd_cell_fsm.sv
module mcd_cell_fsm
  import mcd_pkg::*;
#(
  parameter int CELL_TICKS = 8,
  parameter int TOL        = 1,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              tick,
  input  logic              din,
  output logic              byte_ok,
  output logic [DATA_W-1:0] byte_data
);
  localparam int HALF  = CELL_TICKS / 2;
  localparam int CNT_W = $clog2(3 * CELL_TICKS + 1);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] QUIET     = CNT_W'(CELL_TICKS);
  localparam logic [CNT_W-1:0] SYNC_END  = CNT_W'(2 * CELL_TICKS - TOL - 1);
  localparam logic [CNT_W-1:0] MID_LO    = CNT_W'(CELL_TICKS - TOL);
  localparam logic [CNT_W-1:0] MID_HI    = CNT_W'(CELL_TICKS + TOL);
  localparam logic [CNT_W-1:0] F_MID_LO  = CNT_W'(2 * CELL_TICKS + HALF - TOL);
  localparam logic [CNT_W-1:0] F_MID_HI  = CNT_W'(2 * CELL_TICKS + HALF + TOL);
  localparam logic [CNT_W-1:0] BND_LO    = CNT_W'(HALF - TOL);
  localparam logic [CNT_W-1:0] BND_HI    = CNT_W'(HALF + TOL);
  localparam logic [CNT_W-1:0] F_BND_LO  = CNT_W'(2 * CELL_TICKS - TOL);
  localparam logic [CNT_W-1:0] F_BND_HI  = CNT_W'(2 * CELL_TICKS + TOL);
  localparam logic [CNT_W-1:0] TRL_LO    = CNT_W'(CELL_TICKS + HALF - TOL);
  localparam logic [CNT_W-1:0] TRL_HI    = CNT_W'(CELL_TICKS + HALF + TOL);
  localparam logic [CNT_W-1:0] PAUSE_END = CNT_W'(2 * CELL_TICKS);
  localparam logic [CNT_W-1:0] VOTE_END  = CNT_W'(3);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(DATA_W - 1);

  dec_state_t        st, st_n;
  logic [CNT_W-1:0]  cnt, cnt_n, cur;
  logic              first, first_n, pend, pend_n, prev, prev_n;
  logic [BIT_W-1:0]  nbit, nbit_n;
  logic [DATA_W-1:0] sh, sh_n;
  logic [2:0]        va, va_n, vb, vb_n, vb_full;
  logic              ok_n, err, lvl_chg;
  logic [CNT_W-1:0]  vlo, vhi, blo, bhi, va_lo;

  always_comb begin
    vlo   = first ? F_MID_LO : MID_LO;
    vhi   = first ? F_MID_HI : MID_HI;
    blo   = first ? F_BND_LO : BND_LO;
    bhi   = first ? F_BND_HI : BND_HI;
    va_lo = vlo - CNT_W'(3);
  end

  always_comb begin
    st_n    = st;
    cnt_n   = cnt;
    first_n = first;
    pend_n  = pend;
    prev_n  = prev;
    nbit_n  = nbit;
    sh_n    = sh;
    va_n    = va;
    vb_n    = vb;
    ok_n    = 1'b0;
    err     = 1'b0;
    cur     = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
    lvl_chg = din ^ prev;
    vb_full = {vb[1:0], din};
    if (!enable) begin
      st_n    = ST_START;
      cnt_n   = '0;
      first_n = 1'b0;
      pend_n  = 1'b0;
      nbit_n  = '0;
      prev_n  = din;
    end else if (tick) begin
      prev_n = din;
      cnt_n  = cur;
      case (st)
        ST_START: begin
          if (din) cnt_n = '0;
          else if (cur >= QUIET) st_n = ST_HUNT;
        end
        ST_HUNT: begin
          if (din) begin
            st_n  = ST_SYNC;
            cnt_n = '0;
          end
        end
        ST_SYNC: begin
          if (lvl_chg) err = 1'b1;
          else if (cur == SYNC_END) begin
            st_n    = ST_DATA;
            first_n = 1'b1;
            pend_n  = 1'b0;
            nbit_n  = '0;
          end
        end
        ST_DATA: begin
          if (cur >= va_lo && cur < vlo) va_n = {va[1:0], din};
          if (pend && cur <= VOTE_END) vb_n = vb_full;
          if (pend && cur == VOTE_END) begin
            pend_n = 1'b0;
            if (maj3(va) == maj3(vb_full)) err = 1'b1;
            else begin
              sh_n   = {maj3(vb_full), sh[DATA_W-1:1]};
              nbit_n = nbit + 1'b1;
              if (nbit == LAST_BIT) st_n = ST_TRAIL;
            end
          end
          if (lvl_chg) begin
            if (cur >= vlo && cur <= vhi) begin
              cnt_n   = '0;
              first_n = 1'b0;
              pend_n  = 1'b1;
            end else if (!(cur >= blo && cur <= bhi)) begin
              err = 1'b1;
            end
          end else if (cur > vhi) begin
            err = 1'b1;
          end
        end
        ST_TRAIL: begin
          if (lvl_chg) begin
            if (din && cur >= BND_LO && cur <= BND_HI) begin
              cnt_n = cur;
            end else if (!din && cur >= TRL_LO && cur <= TRL_HI) begin
              st_n  = ST_PAUSE;
              cnt_n = '0;
            end else begin
              err = 1'b1;
            end
          end else if (cur > TRL_HI) begin
            err = 1'b1;
          end
        end
        ST_PAUSE: begin
          if (lvl_chg) err = 1'b1;
          else if (cur == PAUSE_END) begin
            ok_n  = 1'b1;
            st_n  = ST_START;
            cnt_n = '0;
          end
        end
        default: err = 1'b1;
      endcase
      if (err) begin
        st_n    = ST_START;
        cnt_n   = '0;
        first_n = 1'b0;
        pend_n  = 1'b0;
        nbit_n  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_START;
      cnt     <= '0;
      first   <= 1'b0;
      pend    <= 1'b0;
      prev    <= 1'b0;
      nbit    <= '0;
      sh      <= '0;
      va      <= '0;
      vb      <= '0;
      byte_ok <= 1'b0;
    end else begin
      st      <= st_n;
      cnt     <= cnt_n;
      first   <= first_n;
      pend    <= pend_n;
      prev    <= prev_n;
      nbit    <= nbit_n;
      sh      <= sh_n;
      va      <= va_n;
      vb      <= vb_n;
      byte_ok <= ok_n;
    end
  end

  assign byte_data = sh;
endmodule

// File: rtl/mcd_rxreg.sv
module mcd_rxreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_ok,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              rd_status,
  input  logic              rd_data,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              rx_overrun
);
  logic [DATA_W-1:0] data_n;
  logic              full_n, ovr_n, arm, arm_n;

  always_comb begin
    data_n = rx_data;
    full_n = rx_full;
    ovr_n  = rx_overrun;
    arm_n  = arm;
    if (rd_status && rx_overrun) arm_n = 1'b1;
    if (rd_data) begin
      full_n = 1'b0;
      if (arm) begin
        ovr_n = 1'b0;
        arm_n = 1'b0;
      end
    end
    if (byte_ok) begin
      if (!rx_full || rd_data) begin
        full_n = 1'b1;
        data_n = byte_data;
      end else begin
        ovr_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data    <= '0;
      rx_full    <= 1'b0;
      rx_overrun <= 1'b0;
      arm        <= 1'b0;
    end else begin
      rx_data    <= data_n;
      rx_full    <= full_n;
      rx_overrun <= ovr_n;
      arm        <= arm_n;
    end
  end
endmodule

// File: rtl/mcd_rx.sv
module mcd_rx #(
  parameter int BASE_DIV   = 4,
  parameter int RATE_W     = 2,
  parameter int CELL_TICKS = 8,
  parameter int TOL        = 1,
  parameter int DATA_W     = 8,
  parameter int SYNC_STG   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              line_in,
  input  logic              rd_status,
  input  logic              rd_data,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              rx_overrun,
  output logic              irq
);
  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  logic              din, tick, byte_ok;
  logic [DATA_W-1:0] byte_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  mcd_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d_async(line_in), .q(din)
  );

  mcd_prescale #(.BASE_DIV(BASE_DIV), .RATE_W(RATE_W)) u_pre (
    .clk(clk), .rst_n(rst_int_n), .run(enable), .rate_sel(rate_sel), .tick(tick)
  );

  mcd_cell_fsm #(.CELL_TICKS(CELL_TICKS), .TOL(TOL), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_int_n), .enable(enable), .tick(tick), .din(din),
    .byte_ok(byte_ok), .byte_data(byte_data)
  );

  mcd_rxreg #(.DATA_W(DATA_W)) u_reg (
    .clk(clk), .rst_n(rst_int_n), .byte_ok(byte_ok), .byte_data(byte_data),
    .rd_status(rd_status), .rd_data(rd_data),
    .rx_data(rx_data), .rx_full(rx_full), .rx_overrun(rx_overrun)
  );

  assign irq = rx_full | rx_overrun;
endmodule

// File: rtl/mcd_rx_chk.sv
module mcd_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              rd_data,
  input logic              byte_ok,
  input logic [DATA_W-1:0] byte_data,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_full,
  input logic              rx_overrun,
  input logic              irq
);
  // R2
  load_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ok && !rx_full |=> rx_full && rx_data == $past(byte_data));

  // R7
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ok && rx_full && !rd_data |=> rx_overrun && $stable(rx_data));

  // R8
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data && !byte_ok |=> !rx_full);

  // R8
  overrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun && !rd_data |=> rx_overrun);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !byte_ok);

  // R11
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overrun) || $rose(rx_full) |-> irq);
endmodule

bind mcd_rx mcd_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .enable(enable), .rd_data(rd_data),
  .byte_ok(byte_ok), .byte_data(byte_data), .rx_data(rx_data),
  .rx_full(rx_full), .rx_overrun(rx_overrun), .irq(irq)
);

// File: tb/tb_mcd_rx.sv
module tb_mcd_rx;
  localparam int BASE_DIV = 4;

  logic       clk, rst_n, enable, line_in, rd_status, rd_data;
  logic [1:0] rate_sel;
  logic [7:0] rx_data;
  logic       rx_full, rx_overrun, irq;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_data;
  logic       m_full, m_ovr, m_arm;

  mcd_rx dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rate_sel(rate_sel),
    .line_in(line_in), .rd_status(rd_status), .rd_data(rd_data),
    .rx_data(rx_data), .rx_full(rx_full), .rx_overrun(rx_overrun), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int half_clk(input int r);
    return 4 * (BASE_DIV << r);
  endfunction

  task automatic hold(input logic v, input int n);
    line_in = v;
    repeat (n) @(negedge clk);
  endtask

  // mode: 0 good, 1 no mid transition in bit 3, 2 trailing cell low, 3 pulse inside pause
  task automatic send(input logic [7:0] d, input int h, input int mode);
    hold(1'b0, 4 * h);
    hold(1'b1, 4 * h);
    for (int i = 0; i < 8; i++) begin
      if (mode == 1 && i == 3) hold(1'b1, 2 * h);
      else if (d[i]) begin hold(1'b0, h); hold(1'b1, h); end
      else begin hold(1'b1, h); hold(1'b0, h); end
    end
    hold(mode == 2 ? 1'b0 : 1'b1, 2 * h);
    if (mode == 3) begin hold(1'b0, h); hold(1'b1, h); hold(1'b0, 2 * h); end
    else hold(1'b0, 4 * h);
    hold(1'b0, 4 * h);
  endtask

  function automatic void model_rx(input logic [7:0] d);
    if (!m_full) begin m_full = 1'b1; m_data = d; end
    else m_ovr = 1'b1;
  endfunction

  task automatic read_status();
    rd_status = 1'b1; @(negedge clk); rd_status = 1'b0; @(negedge clk);
    if (m_ovr) m_arm = 1'b1;
  endtask

  task automatic read_data();
    rd_data = 1'b1; @(negedge clk); rd_data = 1'b0; @(negedge clk);
    m_full = 1'b0;
    if (m_arm) begin m_ovr = 1'b0; m_arm = 1'b0; end
  endtask

  task automatic check_all(input string req);
    chk(req, rx_full, m_full);
    chk(req, rx_overrun, m_ovr);
    if (m_full || m_ovr) chk(req, rx_data, m_data);
    chk("R11", irq, m_full | m_ovr);
  endtask

  task automatic good(input logic [7:0] d, input int h, input string req);
    send(d, h, 0);
    model_rx(d);
    check_all(req);
  endtask

  initial begin
    process::self().srandom(32'h5EED_0C1D);
    rst_n = 1'b0; enable = 1'b0; line_in = 1'b0; rd_status = 1'b0; rd_data = 1'b0;
    rate_sel = 2'd1;
    m_data = '0; m_full = 1'b0; m_ovr = 1'b0; m_arm = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1: reset state
    check_all("R1");
    // R1: disabled decoder ignores a frame
    send(8'h3C, half_clk(1), 0);
    check_all("R1");

    enable = 1'b1;
    repeat (4) @(negedge clk);
    // R2: basic frames
    good(8'hA5, half_clk(1), "R2");
    read_data(); check_all("R8");
    good(8'h01, half_clk(1), "R2");
    read_data();
    good(8'hFE, half_clk(1), "R2");
    read_data();

    // R3: every rate setting
    for (int r = 0; r < 4; r++) begin
      rate_sel = 2'(r);
      repeat (40) @(negedge clk);
      good(8'(8'h5A ^ r), half_clk(r), "R3");
      read_data();
    end
    rate_sel = 2'd1;
    repeat (40) @(negedge clk);

    // R4: small deviation accepted, large rejected
    good(8'h96, half_clk(1) + 1, "R4"); read_data();
    good(8'h69, half_clk(1) - 1, "R4"); read_data();
    send(8'h33, 3 * BASE_DIV * 2, 0); check_all("R4");
    send(8'h33, 5 * BASE_DIV * 2, 0); check_all("R4");
    good(8'h77, half_clk(1), "R10"); read_data();

    // R5: format error
    send(8'hC3, half_clk(1), 1); check_all("R5");
    good(8'h0F, half_clk(1), "R10"); read_data();

    // R6: end pattern errors
    send(8'hE1, half_clk(1), 2); check_all("R6");
    send(8'hE1, half_clk(1), 3); check_all("R6");
    good(8'h1E, half_clk(1), "R10"); read_data();

    // R7 / R8: overrun handling
    good(8'h11, half_clk(1), "R7");
    good(8'h22, half_clk(1), "R7");
    read_data(); check_all("R8");
    read_status(); check_all("R8");
    good(8'h44, half_clk(1), "R8");
    read_data(); check_all("R8");

    // R9: enable removed mid-frame
    fork
      send(8'hB4, half_clk(1), 0);
      begin
        repeat (12 * half_clk(1)) @(negedge clk);
        enable = 1'b0;
        repeat (3) @(negedge clk);
        enable = 1'b1;
      end
    join
    check_all("R9");
    good(8'h4B, half_clk(1), "R9"); read_data();

    // R2 / R7 / R8: random traffic
    for (int k = 0; k < 14; k++) begin
      int r, j, act;
      logic [7:0] d;
      r = $urandom_range(0, 2);
      rate_sel = 2'(r);
      hold(1'b0, $urandom_range(5, 60));
      j = (r == 0) ? 0 : $urandom_range(0, 2) - 1;
      d = 8'($urandom());
      good(d, half_clk(r) + j, "R2");
      act = $urandom_range(0, 2);
      if (act == 2) read_status();
      if (act != 0) read_data();
      check_all("R8");
    end
    read_status(); read_data(); check_all("R8");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule